// File: doc/BRIEF.md
# Ternary Quantizer with Frame-Adaptive Peak Levels

This block sits after a first-layer convolution engine and turns each convolution result into a 2-bit ternary code. It also emits a 16-bit level word for the digital network that follows. Results arrive as unsigned offset codes, where the mid-scale value `MID = 2^(DW-1)` means zero. An optional rectifier clamps every result at or below mid-scale up to mid-scale. While a frame runs, the block keeps the largest rectified result seen so far.

At each frame strobe, that running peak becomes the stored peak, and the running peak starts again from mid-scale. From the stored peak the block derives the decision thresholds and the level words. So every sample is judged against the dynamic range of the frame before it. Until the first full frame has been seen, the stored peak is full scale.

Top module: `ternary_quant_max`

## Requirements
- R1: One cycle after an input cycle with `s_valid` high, `out_valid` is high. After a cycle with `s_valid` low, it is low. `out_code` and `out_word` change only on valid samples.
- R2: With `relu_en` high, a sample at or below `MID` is treated as exactly `MID`. It gets code 0 and word 0.
- R3: Let `S` be the stored peak minus `MID`, and let `r` be the rectified sample. With `relu_en` high, the code is 0 if `r <= MID + floor(S/3)`, 2 if `r >= MID + floor(2S/3)`, and 1 otherwise. The code 0 test has priority. Code value 3 never appears.
- R4: With `relu_en` low, the raw sample is compared against a single threshold `MID + floor(S/2)`. It gets code 2 if it is at or above the threshold and code 0 otherwise. Code 1 never appears.
- R5: The level word is 0 for code 0, `floor(S/3)` for code 1 and `floor(2S/3)` for code 2, zero-extended to `OW` bits.
- R6: The running peak starts at `MID` and rises to any larger rectified sample on a valid cycle. Cycles with `s_valid` low leave it unchanged, whatever `s_data` holds.
- R7: When `frame_start` is high, the running peak of the frame just closed becomes the stored peak. The thresholds and words derived from it apply already to a sample presented in that same cycle. A sample in the strobe cycle is the first sample of the new frame.
- R8: After reset, the stored peak is full scale (`2^DW-1`). The first `frame_start` after reset only opens a frame and leaves the stored peak unchanged.
- R9: During and directly after reset, `out_valid`, `out_code` and `out_word` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Sample present this cycle |
| s_data | input | DW | Offset-coded convolution result, MID is zero |
| frame_start | input | 1 | First cycle of a new frame |
| relu_en | input | 1 | Rectifier on; selects three-level decision |
| out_valid | output | 1 | Code and word valid |
| out_code | output | 2 | Ternary code 0, 1 or 2 |
| out_word | output | OW | Level word for the downstream network |

## Verification
The bench probes each threshold one code either side. A design with an off-by-one comparison shifts samples between neighbouring codes. It also checks that the first strobe after reset keeps the full-scale levels; a design that loaded the idle running peak there would collapse every threshold to mid-scale. Frames are chosen so that a later frame has a smaller peak than an earlier one, and so that one frame holds only sub-zero samples. A cumulative maximum would keep the old levels, and a broken clamp would let the zero-span thresholds yield code 1. An idle cycle carrying a huge data value must leave the next frame's levels untouched, and the strobe-cycle sample must already see the new levels.

// File: rtl/ttq_pkg.sv
package ttq_pkg;

   typedef enum logic [1:0] {
      TQ_ZERO = 2'd0,
      TQ_LOW  = 2'd1,
      TQ_HIGH = 2'd2
   } tq_code_e;

   // derived per-frame decision set, widths fixed at the widest supported DW
   localparam int unsigned TQ_MAXW = 32;

   function automatic logic [TQ_MAXW-1:0] tq_third(input logic [TQ_MAXW-1:0] span);
      return span / 3;
   endfunction

   function automatic logic [TQ_MAXW-1:0] tq_two_thirds(input logic [TQ_MAXW-1:0] span);
      return (span << 1) / 3;
   endfunction

endpackage

// File: rtl/ttq_relu.sv
module ttq_relu #(
   parameter int unsigned DW = 10
) (
   input  logic [DW-1:0] din,
   input  logic          enable,
   output logic [DW-1:0] dout
);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

   always_comb begin
      if (enable && (din <= MID)) dout = MID;
      else                        dout = din;
   end
endmodule

// File: rtl/ttq_peak.sv
module ttq_peak #(
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_rect,
   input  logic          frame_start,
   output logic [DW-1:0] run_peak,
   output logic          load_levels
);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

   logic          opened_q;
   logic [DW-1:0] base;

   assign base        = frame_start ? MID : run_peak;
   assign load_levels = frame_start && opened_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_peak <= MID;
         opened_q <= 1'b0;
      end else begin
         if (smp_valid && (smp_rect > base)) run_peak <= smp_rect;
         else                                run_peak <= base;
         if (frame_start) opened_q <= 1'b1;
      end
   end
endmodule

// File: rtl/ttq_levels.sv
module ttq_levels #(
   parameter int unsigned DW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] peak,
   output logic [DW-1:0] thr_low,
   output logic [DW-1:0] thr_high,
   output logic [DW-1:0] thr_half,
   output logic [DW-2:0] lvl_low,
   output logic [DW-2:0] lvl_high
);
   import ttq_pkg::*;

   localparam int unsigned SW = DW - 1;
   localparam logic [DW-1:0] MID  = DW'(1) << (DW - 1);
   localparam logic [DW-1:0] FULL = '1;
   localparam logic [TQ_MAXW-1:0] RST_SPAN = TQ_MAXW'(FULL - MID);
   localparam logic [SW-1:0] RST_L1 = SW'(tq_third(RST_SPAN));
   localparam logic [SW-1:0] RST_L2 = SW'(tq_two_thirds(RST_SPAN));
   localparam logic [SW-1:0] RST_LH = SW'(RST_SPAN >> 1);

   logic [SW-1:0] new_l1, new_l2, new_lh;
   logic [SW-1:0] l1_q, l2_q, lh_q;
   logic [SW-1:0] use_l1, use_l2, use_lh;
   logic [TQ_MAXW-1:0] span_w;

   assign span_w = TQ_MAXW'(peak - MID);
   assign new_l1 = SW'(tq_third(span_w));
   assign new_l2 = SW'(tq_two_thirds(span_w));
   assign new_lh = SW'(span_w >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l1_q <= RST_L1;
         l2_q <= RST_L2;
         lh_q <= RST_LH;
      end else if (load) begin
         l1_q <= new_l1;
         l2_q <= new_l2;
         lh_q <= new_lh;
      end
   end

   // the strobe-cycle sample already uses the freshly derived set
   assign use_l1 = load ? new_l1 : l1_q;
   assign use_l2 = load ? new_l2 : l2_q;
   assign use_lh = load ? new_lh : lh_q;

   assign thr_low  = MID + DW'(use_l1);
   assign thr_high = MID + DW'(use_l2);
   assign thr_half = MID + DW'(use_lh);
   assign lvl_low  = use_l1;
   assign lvl_high = use_l2;
endmodule

// File: rtl/ttq_quant.sv
module ttq_quant #(
   parameter int unsigned DW = 10,
   parameter int unsigned OW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [DW-1:0] smp_rect,
   input  logic          three_level,
   input  logic [DW-1:0] thr_low,
   input  logic [DW-1:0] thr_high,
   input  logic [DW-1:0] thr_half,
   input  logic [DW-2:0] lvl_low,
   input  logic [DW-2:0] lvl_high,
   output logic          out_valid,
   output logic [1:0]    out_code,
   output logic [OW-1:0] out_word
);
   import ttq_pkg::*;

   localparam int unsigned SW = DW - 1;

   tq_code_e      code_n;
   logic [SW-1:0] lvl_n;
   logic [OW-1:0] word_n;

   always_comb begin
      if (three_level) begin
         if (smp_rect <= thr_low)       code_n = TQ_ZERO;
         else if (smp_rect >= thr_high) code_n = TQ_HIGH;
         else                           code_n = TQ_LOW;
      end else begin
         code_n = (smp_rect >= thr_half) ? TQ_HIGH : TQ_ZERO;
      end
   end

   always_comb begin
      unique case (code_n)
         TQ_LOW:  lvl_n = lvl_low;
         TQ_HIGH: lvl_n = lvl_high;
         default: lvl_n = '0;
      endcase
   end

   generate
      if (OW >= SW) begin : g_widen
         assign word_n = OW'(lvl_n);
      end else begin : g_narrow
         assign word_n = lvl_n[SW-1 -: OW];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_code  <= 2'd0;
         out_word  <= '0;
      end else begin
         out_valid <= smp_valid;
         if (smp_valid) begin
            out_code <= code_n;
            out_word <= word_n;
         end
      end
   end
endmodule

// File: rtl/ternary_quant_max.sv
module ternary_quant_max #(
   parameter int unsigned DW = 10,
   parameter int unsigned OW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          s_valid,
   input  logic [DW-1:0] s_data,
   input  logic          frame_start,
   input  logic          relu_en,
   output logic          out_valid,
   output logic [1:0]    out_code,
   output logic [OW-1:0] out_word
);
   generate
      if (DW < 4 || DW > 31) begin : g_bad_dw
         $error("ternary_quant_max: DW must lie in 4..31");
      end
      if (OW < 1) begin : g_bad_ow
         $error("ternary_quant_max: OW must be at least 1");
      end
   endgenerate

   logic [DW-1:0] rect;
   logic [DW-1:0] run_peak;
   logic          load_levels;
   logic [DW-1:0] thr_low, thr_high, thr_half;
   logic [DW-2:0] lvl_low, lvl_high;

   ttq_relu #(.DW(DW)) u_relu (
      .din    (s_data),
      .enable (relu_en),
      .dout   (rect)
   );

   ttq_peak #(.DW(DW)) u_peak (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (s_valid),
      .smp_rect    (rect),
      .frame_start (frame_start),
      .run_peak    (run_peak),
      .load_levels (load_levels)
   );

   ttq_levels #(.DW(DW)) u_levels (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_levels),
      .peak     (run_peak),
      .thr_low  (thr_low),
      .thr_high (thr_high),
      .thr_half (thr_half),
      .lvl_low  (lvl_low),
      .lvl_high (lvl_high)
   );

   ttq_quant #(.DW(DW), .OW(OW)) u_quant (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (s_valid),
      .smp_rect    (rect),
      .three_level (relu_en),
      .thr_low     (thr_low),
      .thr_high    (thr_high),
      .thr_half    (thr_half),
      .lvl_low     (lvl_low),
      .lvl_high    (lvl_high),
      .out_valid   (out_valid),
      .out_code    (out_code),
      .out_word    (out_word)
   );
endmodule

// File: rtl/ternary_quant_max_chk.sv
module ternary_quant_max_chk #(
   parameter int unsigned DW = 10,
   parameter int unsigned OW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          s_valid,
   input logic [DW-1:0] s_data,
   input logic          relu_en,
   input logic          out_valid,
   input logic [1:0]    out_code,
   input logic [OW-1:0] out_word
);
   localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid |=> out_valid);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !s_valid |=> !out_valid);

   a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_code != 2'd3));

   a_r4_two_level_only: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && !relu_en) |=> (out_code != 2'd1));

   a_r2_clamp_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && relu_en && (s_data <= MID)) |=> (out_code == 2'd0 && out_word == '0));

   a_r5_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_code == 2'd0) |-> (out_word == '0));
endmodule

bind ternary_quant_max ternary_quant_max_chk #(.DW(DW), .OW(OW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_valid   (s_valid),
   .s_data    (s_data),
   .relu_en   (relu_en),
   .out_valid (out_valid),
   .out_code  (out_code),
   .out_word  (out_word)
);

// File: tb/ternary_quant_max_bench.sv
module ternary_quant_max_bench;
   localparam int unsigned DW = 10;
   localparam int unsigned OW = 16;
   localparam time CLK_PERIOD = 10ns;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          s_valid = 1'b0;
   logic [DW-1:0] s_data = '0;
   logic          frame_start = 1'b0;
   logic          relu_en = 1'b1;
   logic          out_valid;
   logic [1:0]    out_code;
   logic [OW-1:0] out_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ternary_quant_max #(.DW(DW), .OW(OW)) u_ternary_quant_max (
      .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
      .frame_start(frame_start), .relu_en(relu_en),
      .out_valid(out_valid), .out_code(out_code), .out_word(out_word)
   );

   task automatic check(input string req, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   // one sample; outputs sampled just after the capturing edge
   task automatic send(input string req, input int data, input bit fs, input bit relu,
                       input int exp_code, input int exp_word);
      @(negedge clk);
      s_valid = 1'b1; s_data = DW'(data); frame_start = fs; relu_en = relu;
      @(posedge clk); #1;
      s_valid = 1'b0; frame_start = 1'b0;
      check({req, " valid"}, int'(out_valid), 1);
      check({req, " code"}, int'(out_code), exp_code);
      check({req, " word"}, int'(out_word), exp_word);
   endtask

   task automatic t_reset;
      check("R9 valid", int'(out_valid), 0);
      check("R9 code", int'(out_code), 0);
      check("R9 word", int'(out_word), 0);
   endtask

   // full-scale start: S=511, t1=682 t2=852 half=767 words 170/340
   task automatic t_initial_levels;
      send("R3 at t1", 682, 0, 1, 0, 0);
      send("R3 above t1", 683, 0, 1, 1, 170);
      send("R3 below t2", 851, 0, 1, 1, 170);
      send("R5 at t2", 852, 0, 1, 2, 340);
      send("R2 clamp", 100, 0, 1, 0, 0);
      send("R4 off low", 100, 0, 0, 0, 0);
      send("R4 at half", 767, 0, 0, 2, 340);
      send("R4 below half", 766, 0, 0, 0, 0);
   endtask

   task automatic t_first_frame;
      send("R8 first strobe keeps levels", 600, 1, 1, 0, 0);
      send("R8 frame1", 800, 0, 1, 1, 170);
      send("R8 frame1b", 700, 0, 1, 1, 170);
   endtask

   // peak 800: S=288, t1=608 t2=704 half=656 words 96/192
   task automatic t_second_frame;
      send("R7 strobe sample new levels", 704, 1, 1, 2, 192);
      send("R3 frame2 at t1", 608, 0, 1, 0, 0);
      send("R3 frame2 above t1", 609, 0, 1, 1, 96);
      send("R4 frame2 at half", 656, 0, 0, 2, 192);
      send("R4 frame2 below half", 655, 0, 0, 0, 0);
   endtask

   // peak 704 (smaller): S=192, t1=576 t2=640 words 64/128
   task automatic t_smaller_peak;
      send("R7 smaller peak", 640, 1, 1, 2, 128);
      @(negedge clk);
      check("R1 idle after sample", int'(out_valid), 1);
      send("R6 frame3 sub-zero", 100, 0, 1, 0, 0);
   endtask
   // frame3 peak: 640 (strobe sample) -> S=128, t1=554 t2=597 words 42/85

   task automatic t_peak_frame3;
      send("R6 frame4 strobe", 597, 1, 1, 2, 85);
      send("R6 frame4 mid", 555, 0, 1, 1, 42);
   endtask

   // frame with only sub-zero samples -> S=0, every level at mid
   task automatic t_zero_span;
      send("R2 zero-span open", 300, 1, 1, 0, 0);
      send("R2 zero-span low", 50, 0, 1, 0, 0);
      send("R3 zero-span strobe", 513, 1, 1, 2, 0);
      send("R3 zero-span mid", 512, 0, 1, 0, 0);
   endtask

   // idle cycle with a big value must not raise the peak
   task automatic t_idle_ignored;
      @(negedge clk);
      s_valid = 1'b0; s_data = DW'(1000); relu_en = 1'b1;
      @(posedge clk); #1;
      check("R1 idle no valid", int'(out_valid), 0);
      check("R6 idle holds code", int'(out_code), 0);
      send("R6 after idle", 520, 0, 1, 2, 0);
      // peak 520: S=8, t1=514 t2=517 half=516 words 2/5
      send("R6 idle ignored strobe", 517, 1, 1, 2, 5);
      send("R5 small span low", 515, 0, 1, 1, 2);
      send("R4 small span half", 516, 0, 0, 2, 5);
      send("R4 small span below", 515, 0, 0, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_initial_levels();
      t_first_frame();
      t_second_frame();
      t_smaller_peak();
      t_peak_frame3();
      t_zero_span();
      t_idle_ignored();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule